// File: doc/BRIEF.md
# Dual-Mode Serial Word Receiver

This block sits at the front of the control logic of an eight-channel converter. It receives 16-bit command words on a three-wire serial port: a serial clock, a frame-sync line and a data line. A fast system clock oversamples all three pins. Each pin passes through a two-flop synchronizer, and the block finds the edges of the synchronized pins in the system clock domain. Each complete word appears on a parallel output together with a valid strobe that lasts one cycle. The decoding of the word happens downstream.

A static mode pin selects one of two framing rules. In controller framing, frame sync must stay low for the whole word, and the word is committed when frame sync rises. In DSP framing, frame sync only has to mark the start of the word. A frame in DSP framing starts only if a serial-clock falling edge was seen while frame sync was high. A separate chain output repeats the sampled data stream one word later, so several receivers can share one serial bus in a daisy chain.

Top module: `serial_word_rx`

## Requirements
- R1: Each falling serial-clock edge in an active frame shifts one data bit into the word. The first bit taken becomes bit 15 of `word_o` (MSB first), and exactly 16 bits form a word.
- R2: With `mode_uc_i` high (controller framing), the word is committed on the first frame-sync rise after its 16th bit. `word_valid_o` goes high for exactly one system cycle, and `word_o` carries the word from that cycle on.
- R3: In controller framing, if frame sync rises before the 16th falling edge, the partial word is dropped. No strobe follows, and `word_o` keeps its previous value.
- R4: With `mode_uc_i` low (DSP framing), frame sync may rise at any point after it has fallen. The word is committed as soon as the 16th falling edge is seen, and frame sync plays no part in that.
- R5: In DSP framing, a falling edge of frame sync starts a frame only if at least one serial-clock falling edge was seen while frame sync was high since the previous frame-sync fall. Otherwise the bits that follow produce no word.
- R6: Once the 16th bit of a frame is taken, further falling serial-clock edges are ignored until the next falling edge of frame sync. They produce no second strobe and no change of `word_o`.
- R7: With `chain_en_i` high, `chain_o` carries the data bit sampled at falling edge n from the update for edge n+15 until the update for edge n+16. A device that samples it on falling edge n+16 therefore receives bit n. This holds for every falling edge, inside a frame or not.
- R8: With `chain_en_i` low, `chain_o` is low. Right after reset, `word_valid_o` is 0, `word_o` is 0 and `chain_o` is 0.
- R9: A pin edge that is first sampled at system clock edge t acts on the outputs at edge t+2. A commit strobe or a chain update is therefore visible after the third rising system-clock edge that counts the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| mode_uc_i | input | 1 | Framing select: 1 selects controller framing, 0 selects DSP framing |
| chain_en_i | input | 1 | Enables the daisy-chain output |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| fsync_i | input | 1 | Frame-sync pin, active low (asynchronous) |
| sdata_i | input | 1 | Serial data pin (asynchronous) |
| word_o | output | 16 | Last committed word |
| word_valid_o | output | 1 | One-cycle strobe on each commit |
| chain_o | output | 1 | Data stream delayed by one word |

## Verification
Most internal faults in this block show up at the ports within one serial bit time. A wrong bit count or a missed edge gives a strobe that comes a clock early or late, two strobes, or none. An arming flag that is wrong lets a DSP frame start when it should not, or blocks one that should start. A wrong shift order shows as a wrong value of `word_o` in the cycle of the strobe. A wrong delay line shows on `chain_o` within 16 falling edges. The bench keeps its own model that tracks these events clock by clock and compares all three outputs on every cycle. The latency of the synchronizers is therefore checked as well as the values.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int unsigned WORD_BITS  = 16;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } frame_state_e;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;
    logic              prev_q;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], pin_i[g]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q  <= '0;
        prev_q <= 1'b0;
      end else begin
        stg_q  <= stg_d;
        prev_q <= stg_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = stg_q[STAGES-1];
    assign rise_o[g] = stg_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~stg_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/swr_frame.sv
module swr_frame
  import swr_pkg::*;
#(
  parameter int unsigned W = WORD_BITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_uc_i,
  input  logic         sclk_fall_i,
  input  logic         fs_fall_i,
  input  logic         fs_rise_i,
  input  logic         fs_lvl_i,
  input  logic         din_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  frame_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     sh_q, sh_d;
  logic [W-1:0]     word_q, word_d;
  logic             valid_q, valid_d;
  logic             armed_q, armed_d;

  // Arming tracks serial-clock falls seen while frame sync is high.
  always_comb begin
    armed_d = armed_q;
    if (fs_fall_i) begin
      armed_d = 1'b0;
    end else if (sclk_fall_i && fs_lvl_i) begin
      armed_d = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (fs_fall_i) begin
      if (mode_uc_i || armed_q) begin
        state_d = ST_SHIFT;
        cnt_d   = '0;
      end else begin
        state_d = ST_IDLE;
      end
    end else begin
      unique case (state_q)
        ST_SHIFT: begin
          if (mode_uc_i && fs_rise_i) begin
            state_d = ST_IDLE;
          end else if (sclk_fall_i) begin
            sh_d  = {sh_q[W-2:0], din_i};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              state_d = ST_HOLD;
              if (!mode_uc_i) begin
                word_d  = {sh_q[W-2:0], din_i};
                valid_d = 1'b1;
              end
            end
          end
        end
        ST_HOLD: begin
          if (mode_uc_i && fs_rise_i) begin
            word_d  = sh_q;
            valid_d = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      valid_q <= valid_d;
      armed_q <= armed_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R2: strobe lasts a single cycle
  p_valid_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R6: the word only changes along with a strobe
  p_word_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(word_q));
  // R2: controller commits follow a frame-sync rise
  p_uc_commit_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(mode_uc_i)) |-> $past(fs_rise_i));
  // R4: DSP commits follow a serial-clock fall
  p_dsp_commit_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !$past(mode_uc_i)) |-> $past(sclk_fall_i));
  // R5: a DSP frame only opens when armed
  p_dsp_start_armed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && $past(state_q) != ST_SHIFT && !$past(mode_uc_i))
      |-> $past(armed_q));
  // R1: bit count never passes the word length
  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(W));
endmodule

// File: rtl/swr_chain.sv
module swr_chain #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic bit_i,
  input  logic en_i,
  output logic out_o
);
  logic [DEPTH-1:0] dly_q, dly_d;

  always_comb begin
    dly_d = dly_q;
    if (shift_i) begin
      dly_d = {dly_q[DEPTH-2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
    end else begin
      dly_q <= dly_d;
    end
  end

  assign out_o = en_i & dly_q[DEPTH-1];

  // R7: the delay line moves only on a serial-clock fall
  p_chain_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(dly_q));
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import swr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_uc_i,
  input  logic                 chain_en_i,
  input  logic                 sclk_i,
  input  logic                 fsync_i,
  input  logic                 sdata_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_valid_o,
  output logic                 chain_o
);
  localparam int unsigned PINS  = 3;
  localparam int unsigned P_CLK = 0;
  localparam int unsigned P_FS  = 1;
  localparam int unsigned P_DAT = 2;

  logic [PINS-1:0] pins, lvl, rise, fall;

  assign pins[P_CLK] = sclk_i;
  assign pins[P_FS]  = fsync_i;
  assign pins[P_DAT] = sdata_i;

  swr_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  swr_frame #(.W(WORD_BITS)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_uc_i   (mode_uc_i),
    .sclk_fall_i (fall[P_CLK]),
    .fs_fall_i   (fall[P_FS]),
    .fs_rise_i   (rise[P_FS]),
    .fs_lvl_i    (lvl[P_FS]),
    .din_i       (lvl[P_DAT]),
    .word_o      (word_o),
    .valid_o     (word_valid_o)
  );

  swr_chain #(.DEPTH(WORD_BITS)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (fall[P_CLK]),
    .bit_i   (lvl[P_DAT]),
    .en_i    (chain_en_i),
    .out_o   (chain_o)
  );
endmodule

// File: tb/serial_word_rx_tb_top.sv
module serial_word_rx_tb_top;
  localparam int HP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_uc = 1'b0;
  logic        chain_en = 1'b0;
  logic        sclk = 1'b0;
  logic        fs = 1'b1;
  logic        din = 1'b0;
  logic [15:0] word;
  logic        valid;
  logic        chain;

  int total = 0;
  int bad = 0;
  int vcount = 0;
  logic [15:0] last_word = '0;
  bit  cq[$];
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  serial_word_rx dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_uc_i    (mode_uc),
    .chain_en_i   (chain_en),
    .sclk_i       (sclk),
    .fsync_i      (fs),
    .sdata_i      (din),
    .word_o       (word),
    .word_valid_o (valid),
    .chain_o      (chain)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: pin history, integer counters, bit queue.
  logic [2:0] h_clk, h_fs, h_din;
  int  m_phase;
  int  m_nbits;
  int  m_acc;
  int  m_word;
  bit  m_valid;
  bit  m_armed;
  bit  m_chain[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      h_clk = '0; h_fs = '0; h_din = '0;
      m_phase = 0; m_nbits = 0; m_acc = 0; m_word = 0;
      m_valid = 0; m_armed = 0;
      m_chain.delete();
    end else begin
      bit sf, ff, fr, lv, d;
      sf = h_clk[2] & ~h_clk[1];
      ff = h_fs[2] & ~h_fs[1];
      fr = ~h_fs[2] & h_fs[1];
      lv = h_fs[1];
      d  = h_din[1];
      m_valid = 0;
      if (ff) begin
        if (mode_uc || m_armed) begin
          m_phase = 1; m_nbits = 0;
        end else begin
          m_phase = 0;
        end
        m_armed = 0;
      end else begin
        if (sf && lv) m_armed = 1;
        if (m_phase == 1) begin
          if (mode_uc && fr) m_phase = 0;
          else if (sf) begin
            m_acc = ((m_acc << 1) | int'(d)) & 16'hFFFF;
            m_nbits++;
            if (m_nbits == 16) begin
              m_phase = 2;
              if (!mode_uc) begin m_word = m_acc; m_valid = 1; end
            end
          end
        end else if (m_phase == 2 && mode_uc && fr) begin
          m_word = m_acc; m_valid = 1; m_phase = 0;
        end
      end
      if (sf) begin
        m_chain.push_back(d);
        if (m_chain.size() > 16) void'(m_chain.pop_front());
      end
      h_clk = {h_clk[1:0], sclk};
      h_fs  = {h_fs[1:0], fs};
      h_din = {h_din[1:0], din};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ce;
      ce = chain_en && (m_chain.size() == 16) ? m_chain[0] : 1'b0;
      chk("R9 cycle model valid", 32'(valid), 32'(m_valid));
      chk("R9 cycle model word", 32'(word), 32'(m_word));
      chk("R9 cycle model chain", 32'(chain), 32'(ce));
      if (valid) begin vcount++; last_word = word; end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit b);
    din = b; sclk = 1'b1; idle(HP);
    cq.push_back(chain);
    sclk = 1'b0; idle(HP);
  endtask

  task automatic send(input logic [15:0] w, input int from, input int to);
    for (int i = from; i <= to; i++) pulse(w[15-i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] cap;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    chk("R8 reset valid", 32'(valid), 0);
    chk("R8 reset word", 32'(word), 0);
    chk("R8 reset chain", 32'(chain), 0);

    // controller framing
    mode_uc = 1'b1; idle(4);
    fs = 1'b0; idle(HP);
    send(16'hA5C3, 0, 15);
    idle(4);
    chk("R2 no commit before rise", 32'(vcount), 0);
    fs = 1'b1; idle(8);
    chk("R2 one strobe", 32'(vcount), 1);
    chk("R1 word msb first", 32'(last_word), 32'h A5C3);

    fs = 1'b0; idle(HP);
    send(16'h0F0F, 0, 9);
    fs = 1'b1; idle(8);
    chk("R3 cancelled no strobe", 32'(vcount), 1);
    chk("R3 word kept", 32'(word), 32'hA5C3);

    fs = 1'b0; idle(HP);
    send(16'h1234, 0, 15);
    pulse(1); pulse(1); pulse(1);
    fs = 1'b1; idle(8);
    chk("R6 controller extra edges count", 32'(vcount), 2);
    chk("R6 controller extra edges word", 32'(word), 32'h1234);

    // DSP framing
    mode_uc = 1'b0; idle(4);
    pulse(0);
    fs = 1'b0; idle(HP);
    send(16'h3C69, 0, 1);
    fs = 1'b1;
    send(16'h3C69, 2, 15);
    idle(8);
    chk("R4 early rise strobe", 32'(vcount), 3);
    chk("R4 early rise word", 32'(word), 32'h3C69);

    fs = 1'b0; idle(HP);
    send(16'hBEEF, 0, 15);
    pulse(1); pulse(0); pulse(1); pulse(1);
    idle(8);
    chk("R6 dsp extra edges count", 32'(vcount), 4);
    chk("R6 dsp extra edges word", 32'(word), 32'hBEEF);

    fs = 1'b1; idle(6);
    fs = 1'b0; idle(HP);
    send(16'h7777, 0, 15);
    idle(8);
    chk("R5 unarmed no strobe", 32'(vcount), 4);
    chk("R5 unarmed word kept", 32'(word), 32'hBEEF);

    fs = 1'b1; idle(4);
    pulse(1);
    fs = 1'b0; idle(HP);
    send(16'h8001, 0, 15);
    idle(8);
    chk("R5 armed frame strobe", 32'(vcount), 5);
    chk("R1 armed frame word", 32'(word), 32'h8001);

    // chain output
    chain_en = 1'b1; fs = 1'b1; idle(4);
    send(16'hC35A, 0, 15);
    cq.delete();
    send(16'h0000, 0, 15);
    cap = '0;
    for (int i = 0; i < 16; i++) cap[15-i] = cq[i];
    chk("R7 chain delay one word", 32'(cap), 32'hC35A);

    chain_en = 1'b0; idle(2);
    cq.delete();
    send(16'hFFFF, 0, 15);
    send(16'hFFFF, 0, 15);
    cap = '0;
    for (int i = 0; i < 32; i++) cap[0] = cap[0] | cq[i];
    chk("R8 chain disabled low", 32'(cap), 0);
    chk("R8 chain disabled now", 32'(chain), 0);

    idle(4);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule